// File: doc/BRIEF.md
# Video colour lookup table

This block converts a stream of 24-bit pixels (8 bits per channel) into 30-bit pixels (10 bits per channel) through one shared table of 256 entries. Each entry carries a 10-bit red, green and blue value. In channel mode, every input channel addresses the table on its own and keeps only its own component, so the table acts as three independent transfer curves, such as gamma. In palette mode, the red input byte is a single index that supplies all three components. In pass mode, each input channel is widened to 10 bits and sent out unchanged.

A 32-bit register bus loads and reads the table and the mode control. Pixels flow through a fixed two-stage pipeline. The mode is sampled on the clock edge that accepts each pixel, so a control write applies to the very next pixel and does not wait for blanking. The table has a single copy. A write made while video is running changes every lookup that comes after it.

Bus state machine. It has three states: `BUS_IDLE`, `BUS_ACCESS` and `BUS_RESP`.
- `BUS_IDLE` goes to `BUS_ACCESS` when `bus_req` is high, and latches the request.
- `BUS_ACCESS` always goes to `BUS_RESP`. In this state a legal write commits, and the response and read data are registered.
- `BUS_RESP` always goes back to `BUS_IDLE`. In this state `bus_ack` or `bus_err` is high.

Pixel modes. The pipeline uses three modes, selected from the control register: `MODE_PASS`, `MODE_CHANNEL` and `MODE_PALETTE`.

Top module: `vclut_top`

## Requirements
- R1: After reset, `bus_ack`, `bus_err` and `pix_out_vld` are low. The control word reads back as 0x0000_0001 (pass enabled, palette disabled).
- R2: A word write to byte address 4*i (for i from 0 to 255) stores entry i. The entry is packed as blue in bits 29:20, green in bits 19:10 and red in bits 9:0. A word read of that address returns the entry, with bits 31:30 reading zero.
- R3: Some accesses are illegal: a non-word access (`bus_size` other than 2, where 0 is byte and 1 is halfword), a word address that is not a multiple of 4, or an address above 0x400. An illegal access gets `bus_err` instead of `bus_ack`, returns zero read data, and leaves the table and the control register unchanged.
- R4: The control word is at byte address 0x400. Bit 8 enables palette mode and bit 0 enables pass mode. All other bits read as zero.
- R5: In pass mode, each output channel equals its 8-bit input channel followed by that channel's two top bits. Pass mode takes priority over palette mode.
- R6: In channel mode, the output red, green and blue components are taken from the entries addressed by input bits 7:0, 15:8 and 23:16 respectively.
- R7: In palette mode, input bits 7:0 select one entry and the output is that whole entry. Input bits 23:8 have no effect.
- R8: A pixel accepted on a clock edge with `pix_in_vld` high appears on the output after the second edge that follows, with `pix_out_vld` high. When no pixel was accepted, `pix_out_vld` is low.
- R9: A control write commits on the edge that ends `BUS_ACCESS`. The pixel accepted on that same edge uses the old mode. Every later pixel uses the new mode.
- R10: A table write commits on the edge that ends `BUS_ACCESS`. A pixel accepted on that same edge that reads the same entry gets the old contents. Later pixels get the new contents.
- R11: Each request accepted in `BUS_IDLE` gets exactly one response: `bus_ack` or `bus_err`, never both, high for one cycle, two edges after acceptance. Read data is valid in that cycle and zero otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_req | input | 1 | Request, held until the response |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 11 | Byte address |
| bus_size | input | 2 | Access size: 0 byte, 1 halfword, 2 word |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid while `bus_ack` is high |
| bus_ack | output | 1 | Successful completion |
| bus_err | output | 1 | Illegal access completion |
| pix_in_vld | input | 1 | Input pixel valid |
| pix_in | input | 24 | Input pixel: blue 23:16, green 15:8, red 7:0 |
| pix_out_vld | output | 1 | Output pixel valid |
| pix_out | output | 30 | Output pixel: blue 29:20, green 19:10, red 9:0 |

## Verification
Two things can fall on the same clock edge: a bus write that commits in `BUS_ACCESS` and the acceptance of a pixel that looks up the same entry or depends on the same control bit. The bench provokes this in two ways. It holds the red index fixed on a continuous valid stream while it rewrites that entry. It also changes the mode while pixels are streaming. The reference model evaluates each pixel before it applies the pending write on the same edge. Under that model, the coinciding pixel must show the old entry or mode and the next one the new.

// File: rtl/vclut_pkg.sv
package vclut_pkg;

    localparam int BUS_W = 32;

    // access size codes on bus_size
    localparam logic [1:0] SZ_BYTE = 2'd0;
    localparam logic [1:0] SZ_HALF = 2'd1;
    localparam logic [1:0] SZ_WORD = 2'd2;

    // control word bit positions
    localparam int CTRL_PASS_BIT = 0;
    localparam int CTRL_PAL_BIT  = 8;

    typedef enum logic [1:0] {
        BUS_IDLE   = 2'd0,
        BUS_ACCESS = 2'd1,
        BUS_RESP   = 2'd2
    } bus_state_t;

    typedef enum logic [1:0] {
        MODE_PASS    = 2'd0,
        MODE_CHANNEL = 2'd1,
        MODE_PALETTE = 2'd2
    } lut_mode_t;

endpackage

// File: rtl/vclut_bank.sv
// One component of the table: bus write/read port plus a registered pixel read port.
module vclut_bank #(
    parameter int IDX_W = 8,
    parameter int DW    = 10
) (
    input  logic             clk,
    input  logic             wr_en,
    input  logic [IDX_W-1:0] bus_idx,
    input  logic [DW-1:0]    wr_data,
    output logic [DW-1:0]    bus_rd_data,
    input  logic [IDX_W-1:0] pix_idx,
    output logic [DW-1:0]    pix_rd_data
);

    localparam int DEPTH = 1 << IDX_W;

    logic [DW-1:0] mem [DEPTH];

    // contents are not reset; the pixel read sees the value before a same-edge write
    always_ff @(posedge clk) begin
        if (wr_en) begin
            mem[bus_idx] <= wr_data;
        end
        pix_rd_data <= mem[pix_idx];
    end

    assign bus_rd_data = mem[bus_idx];

endmodule

// File: rtl/vclut_bus_fsm.sv
// Register bus decode, control register and request/response state machine.
module vclut_bus_fsm
    import vclut_pkg::*;
#(
    parameter int CH_IN_W  = 8,
    parameter int CH_OUT_W = 10,
    parameter int ADDR_W   = CH_IN_W + 3
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  bus_req,
    input  logic                  bus_we,
    input  logic [ADDR_W-1:0]     bus_addr,
    input  logic [1:0]            bus_size,
    input  logic [BUS_W-1:0]      bus_wdata,
    output logic [BUS_W-1:0]      bus_rdata,
    output logic                  bus_ack,
    output logic                  bus_err,
    output logic                  tab_we,
    output logic [CH_IN_W-1:0]    tab_idx,
    output logic [3*CH_OUT_W-1:0] tab_wdata,
    input  logic [3*CH_OUT_W-1:0] tab_rdata,
    output logic                  ctrl_pass,
    output logic                  ctrl_pal
);

    localparam int TAB_W = 3 * CH_OUT_W;
    localparam int PAD_W = BUS_W - TAB_W;

    bus_state_t state_q;
    bus_state_t state_nx;

    logic              req_we_q;
    logic [ADDR_W-1:0] req_addr_q;
    logic [1:0]        req_size_q;
    logic [BUS_W-1:0]  req_wdata_q;

    logic hit_table;
    logic hit_ctrl;
    logic legal;
    logic [BUS_W-1:0] ctrl_word;
    logic unused_wdata_hi;

    // ---------------- state register ----------------
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= BUS_IDLE;
        end else begin
            state_q <= state_nx;
        end
    end

    // ---------------- next state ----------------
    always_comb begin
        state_nx = state_q;
        unique case (state_q)
            BUS_IDLE:   state_nx = bus_req ? BUS_ACCESS : BUS_IDLE;
            BUS_ACCESS: state_nx = BUS_RESP;
            BUS_RESP:   state_nx = BUS_IDLE;
            default:    state_nx = BUS_IDLE;
        endcase
    end

    // ---------------- request capture ----------------
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            req_we_q    <= 1'b0;
            req_addr_q  <= '0;
            req_size_q  <= SZ_BYTE;
            req_wdata_q <= '0;
        end else if (state_q == BUS_IDLE && bus_req) begin
            req_we_q    <= bus_we;
            req_addr_q  <= bus_addr;
            req_size_q  <= bus_size;
            req_wdata_q <= bus_wdata;
        end
    end

    // ---------------- address decode ----------------
    always_comb begin
        hit_table = (req_addr_q[ADDR_W-1] == 1'b0);
        hit_ctrl  = (req_addr_q == {1'b1, {(ADDR_W-1){1'b0}}});
        legal     = (req_size_q == SZ_WORD) && (req_addr_q[1:0] == 2'b00)
                    && (hit_table || hit_ctrl);
    end

    assign tab_idx   = req_addr_q[ADDR_W-2:2];
    assign tab_wdata = req_wdata_q[TAB_W-1:0];
    assign tab_we    = (state_q == BUS_ACCESS) && req_we_q && legal && hit_table;

    assign unused_wdata_hi = ^req_wdata_q[BUS_W-1:TAB_W];

    always_comb begin
        ctrl_word                = '0;
        ctrl_word[CTRL_PASS_BIT] = ctrl_pass;
        ctrl_word[CTRL_PAL_BIT]  = ctrl_pal;
    end

    // ---------------- control register ----------------
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctrl_pass <= 1'b1;
            ctrl_pal  <= 1'b0;
        end else if (state_q == BUS_ACCESS && req_we_q && legal && hit_ctrl) begin
            ctrl_pass <= req_wdata_q[CTRL_PASS_BIT];
            ctrl_pal  <= req_wdata_q[CTRL_PAL_BIT];
        end
    end

    // ---------------- outputs ----------------
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            bus_ack   <= 1'b0;
            bus_err   <= 1'b0;
            bus_rdata <= '0;
        end else begin
            unique case (state_q)
                BUS_ACCESS: begin
                    bus_ack <= legal;
                    bus_err <= !legal;
                    if (legal && !req_we_q) begin
                        bus_rdata <= hit_table ? {{PAD_W{1'b0}}, tab_rdata} : ctrl_word;
                    end else begin
                        bus_rdata <= '0;
                    end
                end
                BUS_IDLE, BUS_RESP: begin
                    bus_ack   <= 1'b0;
                    bus_err   <= 1'b0;
                    bus_rdata <= '0;
                end
                default: begin
                    bus_ack   <= 1'b0;
                    bus_err   <= 1'b0;
                    bus_rdata <= '0;
                end
            endcase
        end
    end

endmodule

// File: rtl/vclut_pipe.sv
// Two-stage pixel path: mode capture and bank addressing, then output select.
module vclut_pipe
    import vclut_pkg::*;
#(
    parameter int CH_IN_W  = 8,
    parameter int CH_OUT_W = 10
) (
    input  logic                              clk,
    input  logic                              rst_n,
    input  logic                              ctrl_pass,
    input  logic                              ctrl_pal,
    input  logic                              pix_in_vld,
    input  logic [3*CH_IN_W-1:0]              pix_in,
    output logic [2:0][CH_IN_W-1:0]           bank_idx,
    input  logic [2:0][CH_OUT_W-1:0]          bank_rd,
    output logic                              pix_out_vld,
    output logic [3*CH_OUT_W-1:0]             pix_out
);

    localparam int EXT_W = CH_OUT_W - CH_IN_W;

    lut_mode_t mode_now;
    lut_mode_t s1_mode;
    logic      s1_vld;

    logic [2:0][CH_IN_W-1:0]  chan_in;
    logic [2:0][CH_OUT_W-1:0] chan_wide;
    logic [3*CH_OUT_W-1:0]    s1_wide;

    // pass mode wins over palette mode
    always_comb begin
        if (ctrl_pass) begin
            mode_now = MODE_PASS;
        end else if (ctrl_pal) begin
            mode_now = MODE_PALETTE;
        end else begin
            mode_now = MODE_CHANNEL;
        end
    end

    for (genvar k = 0; k < 3; k++) begin : g_chan
        assign chan_in[k]   = pix_in[k*CH_IN_W +: CH_IN_W];
        assign chan_wide[k] = {chan_in[k], chan_in[k][CH_IN_W-1 -: EXT_W]};
        // palette mode drives every bank from the red byte
        assign bank_idx[k]  = (mode_now == MODE_PALETTE) ? chan_in[0] : chan_in[k];
    end

    // stage 1: capture mode and widened input alongside the bank reads
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s1_vld  <= 1'b0;
            s1_mode <= MODE_PASS;
            s1_wide <= '0;
        end else begin
            s1_vld  <= pix_in_vld;
            s1_mode <= mode_now;
            s1_wide <= chan_wide;
        end
    end

    // stage 2: output select
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pix_out_vld <= 1'b0;
            pix_out     <= '0;
        end else begin
            pix_out_vld <= s1_vld;
            unique case (s1_mode)
                MODE_PASS:                  pix_out <= s1_wide;
                MODE_CHANNEL, MODE_PALETTE: pix_out <= bank_rd;
                default:                    pix_out <= s1_wide;
            endcase
        end
    end

endmodule

// File: rtl/vclut_top.sv
module vclut_top
    import vclut_pkg::*;
#(
    parameter  int CH_IN_W  = 8,
    parameter  int CH_OUT_W = 10,
    localparam int ADDR_W   = CH_IN_W + 3
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  bus_req,
    input  logic                  bus_we,
    input  logic [ADDR_W-1:0]     bus_addr,
    input  logic [1:0]            bus_size,
    input  logic [BUS_W-1:0]      bus_wdata,
    output logic [BUS_W-1:0]      bus_rdata,
    output logic                  bus_ack,
    output logic                  bus_err,
    input  logic                  pix_in_vld,
    input  logic [3*CH_IN_W-1:0]  pix_in,
    output logic                  pix_out_vld,
    output logic [3*CH_OUT_W-1:0] pix_out
);

    logic                     ctrl_pass;
    logic                     ctrl_pal;
    logic                     tab_we;
    logic [CH_IN_W-1:0]       tab_idx;
    logic [3*CH_OUT_W-1:0]    tab_wdata;
    logic [3*CH_OUT_W-1:0]    tab_rdata;
    logic [2:0][CH_IN_W-1:0]  bank_idx;
    logic [2:0][CH_OUT_W-1:0] bank_rd;

    vclut_bus_fsm #(
        .CH_IN_W (CH_IN_W),
        .CH_OUT_W(CH_OUT_W),
        .ADDR_W  (ADDR_W)
    ) bus_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .bus_req  (bus_req),
        .bus_we   (bus_we),
        .bus_addr (bus_addr),
        .bus_size (bus_size),
        .bus_wdata(bus_wdata),
        .bus_rdata(bus_rdata),
        .bus_ack  (bus_ack),
        .bus_err  (bus_err),
        .tab_we   (tab_we),
        .tab_idx  (tab_idx),
        .tab_wdata(tab_wdata),
        .tab_rdata(tab_rdata),
        .ctrl_pass(ctrl_pass),
        .ctrl_pal (ctrl_pal)
    );

    // one bank per component; index 0 red, 1 green, 2 blue
    for (genvar k = 0; k < 3; k++) begin : g_bank
        vclut_bank #(
            .IDX_W(CH_IN_W),
            .DW   (CH_OUT_W)
        ) bank_i (
            .clk        (clk),
            .wr_en      (tab_we),
            .bus_idx    (tab_idx),
            .wr_data    (tab_wdata[k*CH_OUT_W +: CH_OUT_W]),
            .bus_rd_data(tab_rdata[k*CH_OUT_W +: CH_OUT_W]),
            .pix_idx    (bank_idx[k]),
            .pix_rd_data(bank_rd[k])
        );
    end

    vclut_pipe #(
        .CH_IN_W (CH_IN_W),
        .CH_OUT_W(CH_OUT_W)
    ) pipe_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .ctrl_pass  (ctrl_pass),
        .ctrl_pal   (ctrl_pal),
        .pix_in_vld (pix_in_vld),
        .pix_in     (pix_in),
        .bank_idx   (bank_idx),
        .bank_rd    (bank_rd),
        .pix_out_vld(pix_out_vld),
        .pix_out    (pix_out)
    );

endmodule

// File: rtl/vclut_chk.sv
module vclut_chk #(
    parameter int CH_IN_W  = 8,
    parameter int CH_OUT_W = 10
) (
    input logic                  clk,
    input logic                  rst_n,
    input logic                  bus_ack,
    input logic                  bus_err,
    input logic [31:0]           bus_rdata,
    input logic                  pix_in_vld,
    input logic [3*CH_IN_W-1:0]  pix_in,
    input logic                  pix_out_vld,
    input logic [3*CH_OUT_W-1:0] pix_out,
    input logic                  ctrl_pass,
    input logic                  ctrl_pal
);

    localparam int EXT_W = CH_OUT_W - CH_IN_W;

    logic [1:0] age_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            age_q <= 2'd0;
        end else if (age_q != 2'd3) begin
            age_q <= age_q + 2'd1;
        end
    end

    function automatic logic [3*CH_OUT_W-1:0] widen(input logic [3*CH_IN_W-1:0] p);
        logic [3*CH_OUT_W-1:0] w;
        for (int k = 0; k < 3; k++) begin
            w[k*CH_OUT_W +: CH_OUT_W] = {p[k*CH_IN_W +: CH_IN_W], p[k*CH_IN_W + CH_IN_W - 1 -: EXT_W]};
        end
        return w;
    endfunction

    // R11
    ack_err_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(bus_ack && bus_err));

    // R11
    resp_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_ack || bus_err) |=> !(bus_ack || bus_err));

    // R2
    rdata_top_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        bus_ack |-> (bus_rdata[31:30] == 2'b00));

    // R3
    err_ctrl_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
        bus_err |-> ($stable(ctrl_pass) && $stable(ctrl_pal) && bus_rdata == 32'd0));

    // R8
    vld_latency_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (age_q >= 2'd2) |-> (pix_out_vld == $past(pix_in_vld, 2)));

    // R5
    pass_data_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (age_q >= 2'd2 && $past(pix_in_vld, 2) && $past(ctrl_pass, 2))
            |-> (pix_out == widen($past(pix_in, 2))));

endmodule

bind vclut_top vclut_chk #(
    .CH_IN_W (CH_IN_W),
    .CH_OUT_W(CH_OUT_W)
) chk_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .bus_ack    (bus_ack),
    .bus_err    (bus_err),
    .bus_rdata  (bus_rdata),
    .pix_in_vld (pix_in_vld),
    .pix_in     (pix_in),
    .pix_out_vld(pix_out_vld),
    .pix_out    (pix_out),
    .ctrl_pass  (ctrl_pass),
    .ctrl_pal   (ctrl_pal)
);

// File: tb/vclut_top_tb_top.sv
`timescale 1ns/1ps
module vclut_top_tb_top;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_req = 1'b0;
    logic        bus_we = 1'b0;
    logic [10:0] bus_addr = '0;
    logic [1:0]  bus_size = 2'd2;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        bus_ack;
    logic        bus_err;
    logic        pix_in_vld = 1'b0;
    logic [23:0] pix_in = '0;
    logic        pix_out_vld;
    logic [29:0] pix_out;

    always #5 clk = ~clk;

    vclut_top dut_i (
        .clk(clk), .rst_n(rst_n),
        .bus_req(bus_req), .bus_we(bus_we), .bus_addr(bus_addr), .bus_size(bus_size),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .bus_ack(bus_ack), .bus_err(bus_err),
        .pix_in_vld(pix_in_vld), .pix_in(pix_in), .pix_out_vld(pix_out_vld), .pix_out(pix_out)
    );

    int n_cmp = 0;
    int n_bad = 0;
    bit done = 0;

    task automatic chk(input string tag, input string what, input logic [31:0] act, input logic [31:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s %s actual=%h expected=%h t=%0t", tag, what, act, exp, $time);
        end
    endtask

    // ---------------- reference model ----------------
    logic [9:0] t_r [256];
    logic [9:0] t_g [256];
    logic [9:0] t_b [256];
    logic m_pass, m_pal;
    bit   m_fresh;
    int   m_phase;
    logic m_we; logic [10:0] m_addr; logic [1:0] m_size; logic [31:0] m_wdata;
    string cur_tag = "R11";
    string m_tag;
    logic e_ack, e_err; logic [31:0] e_rdata; string e_btag = "R11";
    logic s1_v; logic [29:0] s1_d; string s1_tag;
    logic e_v;  logic [29:0] e_d;  string e_ptag;

    function automatic logic [9:0] wid(input logic [7:0] c);
        return {c, c[7:6]};
    endfunction

    function automatic bit legal(input logic [10:0] a, input logic [1:0] sz);
        return (sz == 2'd2) && (a[1:0] == 2'b00) && (a <= 11'h400);
    endfunction

    always @(posedge clk) begin
        if (!rst_n) begin
            m_pass = 1; m_pal = 0; m_fresh = 0; m_phase = 0;
            e_ack = 0; e_err = 0; e_rdata = 0;
            s1_v = 0; s1_d = 0; e_v = 0; e_d = 0;
        end else begin
            logic [7:0] r, g, b;
            bit wr_tab; logic [7:0] w;
            wr_tab = (m_phase == 1) && m_we && legal(m_addr, m_size) && (m_addr < 11'h400);
            w = m_addr[9:2];
            // output stage
            e_v = s1_v; e_d = s1_d; e_ptag = s1_tag;
            // input stage, evaluated before any same-edge commit
            s1_v = pix_in_vld;
            r = pix_in[7:0]; g = pix_in[15:8]; b = pix_in[23:16];
            if (m_pass) begin
                s1_d = {wid(b), wid(g), wid(r)}; s1_tag = "R5";
            end else if (m_pal) begin
                s1_d = {t_b[r], t_g[r], t_r[r]}; s1_tag = "R7";
                if (wr_tab && r == w) s1_tag = "R10";
            end else begin
                s1_d = {t_b[b], t_g[g], t_r[r]}; s1_tag = "R6";
                if (wr_tab && (r == w || g == w || b == w)) s1_tag = "R10";
            end
            if (m_fresh) s1_tag = "R9";
            m_fresh = 0;
            // bus
            case (m_phase)
                0: begin
                    e_ack = 0; e_err = 0; e_rdata = 0;
                    if (bus_req) begin
                        m_we = bus_we; m_addr = bus_addr; m_size = bus_size;
                        m_wdata = bus_wdata; m_tag = cur_tag; m_phase = 1;
                    end
                end
                1: begin
                    e_btag = m_tag;
                    e_rdata = 0;
                    if (!legal(m_addr, m_size)) begin
                        e_ack = 0; e_err = 1;
                    end else begin
                        e_ack = 1; e_err = 0;
                        if (m_addr == 11'h400) begin
                            if (m_we) begin
                                m_pass = m_wdata[0]; m_pal = m_wdata[8]; m_fresh = 1;
                            end else begin
                                e_rdata = {23'd0, m_pal, 7'd0, m_pass};
                            end
                        end else begin
                            if (m_we) begin
                                t_r[w] = m_wdata[9:0]; t_g[w] = m_wdata[19:10]; t_b[w] = m_wdata[29:20];
                            end else begin
                                e_rdata = {2'b00, t_b[w], t_g[w], t_r[w]};
                            end
                        end
                    end
                    m_phase = 2;
                end
                default: begin
                    e_ack = 0; e_err = 0; e_rdata = 0; m_phase = 0;
                end
            endcase
        end
    end

    // compare every cycle away from the active edge
    always @(negedge clk) begin
        if (rst_n && !done) begin
            chk("R8", "pix_out_vld", {31'd0, pix_out_vld}, {31'd0, e_v});
            if (e_v) chk(e_ptag, "pix_out", {2'b00, pix_out}, {2'b00, e_d});
            chk(e_err ? e_btag : "R11", "bus_ack", {31'd0, bus_ack}, {31'd0, e_ack});
            chk(e_err ? e_btag : "R11", "bus_err", {31'd0, bus_err}, {31'd0, e_err});
            chk(e_btag, "bus_rdata", bus_rdata, e_rdata);
        end
    end

    // ---------------- stimulus ----------------
    bit pix_run = 0;
    bit coll_mode = 0;
    logic [7:0] coll_idx = 8'h33;

    initial begin
        forever begin
            @(negedge clk);
            if (pix_run) begin
                pix_in_vld = coll_mode ? 1'b1 : (($urandom % 4) != 0);
                pix_in = $urandom;
                if (coll_mode) pix_in[7:0] = coll_idx;
            end else begin
                pix_in_vld = 1'b0;
            end
        end
    end

    task automatic bus_op(input logic we, input logic [10:0] a, input logic [1:0] sz,
                          input logic [31:0] d, input string tag);
        @(negedge clk);
        cur_tag = tag;
        bus_req = 1; bus_we = we; bus_addr = a; bus_size = sz; bus_wdata = d;
        do @(negedge clk); while (!(bus_ack || bus_err));
        bus_req = 0;
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    function automatic logic [31:0] entry_val(input int i);
        logic [9:0] r, g, b;
        r = 10'(i * 3 + 7);
        g = 10'(1023 - i * 2);
        b = 10'(i * 5) ^ 10'h155;
        return {2'b11, b, g, r};
    endfunction

    initial begin : watchdog
        repeat (60000) @(posedge clk);
        if (!done) begin
            done = 1;
            n_cmp++; n_bad++;
            $display("FAIL watchdog: run did not complete actual=timeout expected=done");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    initial begin
        repeat (4) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        // R1: idle outputs straight after reset
        chk("R1", "reset bus_ack", {31'd0, bus_ack}, 32'd0);
        chk("R1", "reset bus_err", {31'd0, bus_err}, 32'd0);
        chk("R1", "reset pix_out_vld", {31'd0, pix_out_vld}, 32'd0);
        bus_op(0, 11'h400, 2'd2, 0, "R1");
        // R2: fill the table; top bits written as ones must read back zero
        for (int i = 0; i < 256; i++) bus_op(1, 11'(i * 4), 2'd2, entry_val(i), "R2");
        bus_op(0, 11'h000, 2'd2, 0, "R2");
        bus_op(0, 11'h0A4, 2'd2, 0, "R2");
        bus_op(0, 11'h3FC, 2'd2, 0, "R2");
        // R3: illegal accesses leave state untouched
        bus_op(1, 11'h014, 2'd0, 32'h0, "R3");
        bus_op(1, 11'h014, 2'd1, 32'h0, "R3");
        bus_op(1, 11'h016, 2'd2, 32'h0, "R3");
        bus_op(1, 11'h404, 2'd2, 32'h0, "R3");
        bus_op(1, 11'h400, 2'd0, 32'h100, "R3");
        bus_op(0, 11'h400, 2'd1, 0, "R3");
        bus_op(0, 11'h014, 2'd2, 0, "R3");
        bus_op(0, 11'h400, 2'd2, 0, "R3");
        // R11: back-to-back reads
        bus_op(0, 11'h008, 2'd2, 0, "R11");
        bus_op(0, 11'h00C, 2'd2, 0, "R11");
        // R5 / R8: pass mode stream with gaps
        pix_run = 1;
        idle(40);
        // R9: switch to channel mode while streaming
        bus_op(1, 11'h400, 2'd2, 32'h0, "R9");
        idle(60);                                       // R6
        bus_op(1, 11'h400, 2'd2, 32'h100, "R9");
        idle(60);                                       // R7
        bus_op(1, 11'h400, 2'd2, 32'h101, "R5");        // pass beats palette
        idle(30);
        // R10: rewrite the entry under a continuous lookup, channel then palette
        bus_op(1, 11'h400, 2'd2, 32'h0, "R9");
        coll_mode = 1;
        idle(4);
        bus_op(1, {1'b0, coll_idx, 2'b00}, 2'd2, 32'h1234_5678, "R10");
        idle(4);
        bus_op(1, 11'h400, 2'd2, 32'h100, "R9");
        idle(4);
        bus_op(1, {1'b0, coll_idx, 2'b00}, 2'd2, 32'h0ABC_DEF1, "R10");
        idle(6);
        coll_mode = 0;
        pix_run = 0;
        // R4: only the two defined control bits stick
        bus_op(1, 11'h400, 2'd2, 32'hFFFF_FFFF, "R4");
        bus_op(0, 11'h400, 2'd2, 0, "R4");
        bus_op(1, 11'h400, 2'd2, 32'hFFFF_FEFE, "R4");
        bus_op(0, 11'h400, 2'd2, 0, "R4");
        idle(6);
        if (!done) begin
            done = 1;
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

endmodule